// File: doc/BRIEF.md
# PWM Global Channel-Enable and Interrupt Register File

This block holds the global control state of a four-channel pulse-width modulator behind a simple memory-mapped bus. Software starts and stops channels through a set register and a clear register. A bit written as one acts on its channel and a bit written as zero leaves it alone, so no read-modify-write sequence is needed. The running channels can be read back, and the block drives a per-channel run-enable vector to the channel counters.

Each channel counter sends a one-cycle period-end pulse. The block latches it as a pending flag, and that flag clears when software reads the pending register. An interrupt mask is changed the same way as the run state, through a set register and a clear register, and can be read back. One interrupt line combines the masked pending flags. The block also stores a mode word for the clock divider. It decodes the per-channel register windows and forwards those accesses to the channel blocks, which share the bus write data.

Top module: `pwm_global_regs`

## Requirements
- R1: After reset, runEnable is 0, the mask reads 0, no flag is pending and irq is low.
- R2: A write to offset 0x04 sets runEnable bit n for each data bit n (n < 4) that is 1. Data bits that are 0 leave their channel unchanged. The run state reads back in bits [3:0] at offset 0x0C.
- R3: A write to offset 0x08 clears runEnable bit n for each data bit n that is 1, and leaves the other channels unchanged.
- R4: A write to 0x10 sets the matching mask bits and a write to 0x14 clears them. The mask reads back at 0x18. A write to 0x18 does not change the mask.
- R5: A period-end pulse on periodEnd[n] sets pending bit n. A read of offset 0x1C returns the pending bits in [3:0] and clears them.
- R6: A pulse that arrives in the same cycle as a read of 0x1C is not part of the returned value and is still pending after the read.
- R7: irq is high exactly while at least one channel is both pending and unmasked.
- R8: Write data bits [31:4] do not affect the run state or the mask. Read data bits [31:4] are zero at 0x0C, 0x18 and 0x1C.
- R9: Offset 0x00 is a 32-bit read/write mode word, and its value drives modeWord.
- R10: An access at 0x200 + n*0x20 + k (n < 4, k < 0x20) raises chanSel bit n for that cycle, with chanOffset = k and chanWrite equal to busWrite. A read there returns chanRdata[n*32 +: 32]. Outside 0x200..0x27F, chanSel is zero.
- R11: Reads of the write-only offsets (0x04, 0x08, 0x10, 0x14) and of unmapped addresses return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data, shared with channel blocks |
| busRdata | output | 32 | Read data, valid in the access cycle |
| periodEnd | input | 4 | One-cycle period-end pulse per channel |
| runEnable | output | 4 | Per-channel run enable |
| irq | output | 1 | Interrupt request |
| modeWord | output | 32 | Stored mode word for the clock divider |
| chanSel | output | 4 | One-hot channel window select |
| chanWrite | output | 1 | Write qualifier for channel access |
| chanOffset | output | 5 | Byte offset inside the channel window |
| chanRdata | input | 128 | Read data from channel blocks, channel n at [n*32 +: 32] |

## Verification
Every cycle, the assertions check that a set write leaves all written bits set and a clear write leaves them cleared. They also check that the mask holds when no mask register is written, that a pending read with no new pulse empties the flags, that a new pulse is always retained, and that window selects and write strobes are never more than one-hot. Only the bench scenarios show the values that read back: that zero bits and upper bits have no effect, that a pulse coinciding with a status read stays out of the returned value but remains pending, and that the read data is correct for each channel window and unmapped address.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_MODE,
    SRC_RUN,
    SRC_MASK,
    SRC_PEND,
    SRC_CHAN
  } rdSrcE;

  typedef struct packed {
    logic  wrMode;
    logic  wrEna;
    logic  wrDis;
    logic  wrIen;
    logic  wrIdis;
    logic  rdPend;
    rdSrcE rdSrc;
  } strobeS;

  // word index of global registers (byte offset / 4)
  localparam logic [2:0] W_MODE = 3'd0;
  localparam logic [2:0] W_ENA  = 3'd1;
  localparam logic [2:0] W_DIS  = 3'd2;
  localparam logic [2:0] W_RUN  = 3'd3;
  localparam logic [2:0] W_IEN  = 3'd4;
  localparam logic [2:0] W_IDIS = 3'd5;
  localparam logic [2:0] W_MASK = 3'd6;
  localparam logic [2:0] W_PEND = 3'd7;

endpackage

// File: rtl/pwmg_ctrl.sv
module pwmg_ctrl
  import pwmg_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NCH         = 4,
  parameter int BANK_BASE   = 512,
  parameter int BANK_STRIDE = 32,
  localparam int OFF_W = $clog2(BANK_STRIDE),
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobeS            strobe,
  output logic [NCH-1:0]    chanSel,
  output logic              chanWrite,
  output logic [OFF_W-1:0]  chanOffset,
  output logic [IDX_W-1:0]  chanIdx
);

  localparam int BLK_W = ADDR_W - OFF_W;
  localparam logic [BLK_W-1:0] BASE_BLK = BLK_W'(BANK_BASE / BANK_STRIDE);
  localparam logic [BLK_W-1:0] NCH_V    = BLK_W'(NCH);

  logic [BLK_W-1:0] blk;
  logic [BLK_W-1:0] blkRel;
  logic             inBank;
  logic             globalHit;
  logic [2:0]       word;

  assign blk        = busAddr[ADDR_W-1:OFF_W];
  assign blkRel     = blk - BASE_BLK;
  assign inBank     = (blkRel < NCH_V);
  assign globalHit  = (blk == '0);
  assign word       = busAddr[4:2];
  assign chanIdx    = blkRel[IDX_W-1:0];
  assign chanOffset = busAddr[OFF_W-1:0];
  assign chanWrite  = busSel & busWrite & inBank;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign chanSel[i] = busSel & inBank & (chanIdx == IDX_W'(i));
  end

  always_comb begin
    strobe = '0;
    strobe.rdSrc = SRC_NONE;
    if (busSel && globalHit) begin
      if (busWrite) begin
        unique case (word)
          W_MODE:  strobe.wrMode = 1'b1;
          W_ENA:   strobe.wrEna  = 1'b1;
          W_DIS:   strobe.wrDis  = 1'b1;
          W_IEN:   strobe.wrIen  = 1'b1;
          W_IDIS:  strobe.wrIdis = 1'b1;
          default: ;
        endcase
      end else begin
        unique case (word)
          W_MODE:  strobe.rdSrc = SRC_MODE;
          W_RUN:   strobe.rdSrc = SRC_RUN;
          W_MASK:  strobe.rdSrc = SRC_MASK;
          W_PEND: begin
            strobe.rdSrc  = SRC_PEND;
            strobe.rdPend = 1'b1;
          end
          default: strobe.rdSrc = SRC_NONE;
        endcase
      end
    end else if (busSel && inBank && !busWrite) begin
      strobe.rdSrc = SRC_CHAN;
    end
  end

  AST_CHAN_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanSel)); // R10
  AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrMode, strobe.wrEna, strobe.wrDis, strobe.wrIen, strobe.wrIdis})); // R11
  AST_NO_WR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite) |-> !(strobe.wrEna || strobe.wrDis || strobe.wrIen || strobe.wrIdis)); // R11

endmodule

// File: rtl/pwmg_dpath.sv
module pwmg_dpath
  import pwmg_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeS                strobe,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic [NCH-1:0]        periodEnd,
  input  logic [IDX_W-1:0]      chanIdx,
  input  logic [NCH*DATA_W-1:0] chanRdata,
  output logic [NCH-1:0]        runReg,
  output logic [DATA_W-1:0]     modeReg,
  output logic [DATA_W-1:0]     readData,
  output logic                  irq
);

  localparam int PAD_W = DATA_W - NCH;

  logic [NCH-1:0] maskReg;
  logic [NCH-1:0] pendReg;
  logic [NCH-1:0] wrBits;
  logic [NCH-1:0] pendKeep;

  assign wrBits   = busWdata[NCH-1:0];
  assign pendKeep = strobe.rdPend ? '0 : pendReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReg  <= '0;
      maskReg <= '0;
      pendReg <= '0;
      modeReg <= '0;
    end else begin
      if (strobe.wrEna)  runReg  <= runReg | wrBits;
      if (strobe.wrDis)  runReg  <= runReg & ~wrBits;
      if (strobe.wrIen)  maskReg <= maskReg | wrBits;
      if (strobe.wrIdis) maskReg <= maskReg & ~wrBits;
      if (strobe.wrMode) modeReg <= busWdata;
      pendReg <= pendKeep | periodEnd;
    end
  end

  always_comb begin
    unique case (strobe.rdSrc)
      SRC_MODE: readData = modeReg;
      SRC_RUN:  readData = {{PAD_W{1'b0}}, runReg};
      SRC_MASK: readData = {{PAD_W{1'b0}}, maskReg};
      SRC_PEND: readData = {{PAD_W{1'b0}}, pendReg};
      SRC_CHAN: readData = chanRdata[chanIdx*DATA_W +: DATA_W];
      default:  readData = '0;
    endcase
  end

  assign irq = |(pendReg & maskReg);

  AST_ENA_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEna |=> ((runReg & $past(wrBits)) == $past(wrBits))); // R2
  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDis |=> ((runReg & $past(wrBits)) == '0)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrIen || strobe.wrIdis) |=> $stable(maskReg)); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdPend && periodEnd == '0) |=> (pendReg == '0)); // R5
  AST_PULSE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (|periodEnd) |=> ((pendReg & $past(periodEnd)) == $past(periodEnd))); // R6
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> !irq); // R7

endmodule

// File: rtl/pwm_global_regs.sv
module pwm_global_regs
  import pwmg_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int NCH         = 4,
  parameter int BANK_BASE   = 512,
  parameter int BANK_STRIDE = 32,
  localparam int OFF_W = $clog2(BANK_STRIDE),
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NCH-1:0]        periodEnd,
  output logic [NCH-1:0]        runEnable,
  output logic                  irq,
  output logic [DATA_W-1:0]     modeWord,
  output logic [NCH-1:0]        chanSel,
  output logic                  chanWrite,
  output logic [OFF_W-1:0]      chanOffset,
  input  logic [NCH*DATA_W-1:0] chanRdata
);

  strobeS           strobe;
  logic [IDX_W-1:0] chanIdx;

  pwmg_ctrl #(
    .ADDR_W(ADDR_W), .NCH(NCH), .BANK_BASE(BANK_BASE), .BANK_STRIDE(BANK_STRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .strobe(strobe), .chanSel(chanSel), .chanWrite(chanWrite),
    .chanOffset(chanOffset), .chanIdx(chanIdx)
  );

  pwmg_dpath #(.NCH(NCH), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .periodEnd(periodEnd), .chanIdx(chanIdx), .chanRdata(chanRdata),
    .runReg(runEnable), .modeReg(modeWord), .readData(busRdata), .irq(irq)
  );

endmodule

// File: tb/pwm_global_regs_bench.sv
module pwm_global_regs_bench;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0;
  logic         busWrite = 1'b0;
  logic [11:0]  busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [3:0]   periodEnd = '0;
  logic [3:0]   runEnable;
  logic         irq;
  logic [31:0]  modeWord;
  logic [3:0]   chanSel;
  logic         chanWrite;
  logic [4:0]   chanOffset;
  logic [127:0] chanRdata;

  int checks = 0;
  int failures = 0;
  string       tagQ[$];
  logic [31:0] expQ[$];

  assign chanRdata = {32'h3333_0003, 32'h2222_0002, 32'h1111_0001, 32'h0000_5A00};

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_global_regs u_pwm_global_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .periodEnd(periodEnd),
    .runEnable(runEnable), .irq(irq), .modeWord(modeWord), .chanSel(chanSel),
    .chanWrite(chanWrite), .chanOffset(chanOffset), .chanRdata(chanRdata)
  );

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data in the middle of each read cycle
  always @(negedge clk) begin
    if (busSel && !busWrite && tagQ.size() > 0) begin
      string t;
      logic [31:0] e;
      t = tagQ.pop_front();
      e = expQ.pop_front();
      checkVal(t, busRdata, e);
    end
  end

  task automatic busStart(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          input logic [3:0] pe);
    busSel = 1'b1; busWrite = wr; busAddr = a; busWdata = d; periodEnd = pe;
  endtask

  task automatic busEnd();
    busSel = 1'b0; busWrite = 1'b0; busAddr = '0; busWdata = '0; periodEnd = '0;
  endtask

  task automatic busAccess(input logic wr, input logic [11:0] a, input logic [31:0] d,
                           input logic [3:0] pe);
    busStart(wr, a, d, pe);
    @(posedge clk); #1;
    busEnd();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAccess(1'b1, a, d, 4'b0);
  endtask

  task automatic rdExpect(input logic [11:0] a, input logic [31:0] exp, input string tag,
                          input logic [3:0] pe);
    tagQ.push_back(tag);
    expQ.push_back(exp);
    busAccess(1'b0, a, 32'h0, pe);
  endtask

  task automatic pulse(input logic [3:0] pe);
    periodEnd = pe;
    @(posedge clk); #1;
    periodEnd = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    checkVal("R1 runEnable", {28'h0, runEnable}, 32'h0);
    checkVal("R1 irq", {31'h0, irq}, 32'h0);
    rdExpect(12'h00C, 32'h0, "R1 status", 4'b0);
    rdExpect(12'h018, 32'h0, "R1 mask", 4'b0);
    rdExpect(12'h01C, 32'h0, "R1 pending", 4'b0);

    // R9 mode word
    wr(12'h000, 32'hA5A5_0F0F);
    checkVal("R9 modeWord", modeWord, 32'hA5A5_0F0F);
    rdExpect(12'h000, 32'hA5A5_0F0F, "R9 mode readback", 4'b0);

    // R2 enable set, zero bits no effect
    wr(12'h004, 32'h5);
    checkVal("R2 enable 0101", {28'h0, runEnable}, 32'h5);
    wr(12'h004, 32'h2);
    checkVal("R2 zero bits keep", {28'h0, runEnable}, 32'h7);
    rdExpect(12'h00C, 32'h7, "R2 status read", 4'b0);
    // R8 upper write bits ignored
    wr(12'h004, 32'hFFFF_FFF0);
    checkVal("R8 upper enable bits", {28'h0, runEnable}, 32'h7);
    // R3 disable
    wr(12'h008, 32'h1);
    checkVal("R3 disable ch0", {28'h0, runEnable}, 32'h6);
    rdExpect(12'h00C, 32'h6, "R3 status read", 4'b0);
    // R11 write-only offsets read zero
    rdExpect(12'h008, 32'h0, "R11 disable reads zero", 4'b0);
    rdExpect(12'h004, 32'h0, "R11 enable reads zero", 4'b0);

    // R4 mask set/clear, mask register read-only
    wr(12'h010, 32'hC);
    rdExpect(12'h018, 32'hC, "R4 mask after set", 4'b0);
    wr(12'h014, 32'h4);
    rdExpect(12'h018, 32'h8, "R4 mask after clear", 4'b0);
    wr(12'h018, 32'hF);
    rdExpect(12'h018, 32'h8, "R4 mask write ignored", 4'b0);

    // R5/R7 pending and irq
    pulse(4'b0001);
    checkVal("R7 masked pending no irq", {31'h0, irq}, 32'h0);
    rdExpect(12'h01C, 32'h1, "R5 pending read", 4'b0);
    rdExpect(12'h01C, 32'h0, "R5 cleared by read", 4'b0);
    pulse(4'b1000);
    checkVal("R7 unmasked pending irq", {31'h1, irq} & 32'h1, 32'h1);
    // R6 pulse during read stays pending
    rdExpect(12'h01C, 32'h8, "R6 read excludes new pulse", 4'b0010);
    checkVal("R7 irq drops after read", {31'h0, irq}, 32'h0);
    rdExpect(12'h01C, 32'h2, "R6 new pulse still pending", 4'b0);
    checkVal("R5 pending empty irq low", {31'h0, irq}, 32'h0);

    // R10 channel window write
    busStart(1'b1, 12'h244, 32'hDEAD_BEEF, 4'b0);
    #2;
    checkVal("R10 chanSel ch2", {28'h0, chanSel}, 32'h4);
    checkVal("R10 chanOffset", {27'h0, chanOffset}, 32'h4);
    checkVal("R10 chanWrite", {31'h0, chanWrite}, 32'h1);
    @(posedge clk); #1;
    busEnd();
    checkVal("R11 bank write leaves run", {28'h0, runEnable}, 32'h6);
    // R10 channel read
    rdExpect(12'h260, 32'h3333_0003, "R10 ch3 read", 4'b0);
    rdExpect(12'h23C, 32'h1111_0001, "R10 ch1 read", 4'b0);
    // outside window
    busStart(1'b0, 12'h280, 32'h0, 4'b0);
    #2;
    checkVal("R10 chanSel outside", {28'h0, chanSel}, 32'h0);
    checkVal("R11 outside window reads zero", busRdata, 32'h0);
    @(posedge clk); #1;
    busEnd();
    rdExpect(12'h100, 32'h0, "R11 unmapped read", 4'b0);
    wr(12'h100, 32'hF);
    checkVal("R11 unmapped write run", {28'h0, runEnable}, 32'h6);
    rdExpect(12'h018, 32'h8, "R11 unmapped write mask", 4'b0);

    if (tagQ.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard left=%0d expected=0", tagQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule